// File: doc/BRIEF.md
# Nametable Source Router with Per-Tile Palette Capture

This block sits on the nametable side of a tile-based video engine. It takes the byte address space of four 1 KiB screen quadrants and steers each access to one of four sources: page 0 or page 1 of the internal screen RAM, a separate 1 KiB expansion RAM, or a pair of fill registers. A byte-wide mapping register picks the source for each quadrant. The fill registers supply one constant tile byte and one constant attribute byte.

In the extended-attribute mode, the renderer's tile fetch does two things. It returns the normal screen byte, and it also reads the expansion RAM at the same offset. From that byte it latches a graphics bank and a 2-bit palette. The renderer's next attribute fetch then returns that palette, spread across a whole attribute byte, in place of the stored attribute. The latched bank and a valid flag leave the block for the pattern fetch logic. Side-effect-free debug reads never disturb this latch.

The video port is a valid/ready request stream. `vid_ready` is held high, so every beat with `vid_valid` high is accepted on that clock edge and the port never applies back-pressure. A read answers exactly one cycle later on `vid_rvalid`/`vid_rdata`. The response path has no ready, so the consumer must take each response in the cycle it appears. Configuration writes use a plain write strobe.

Top module: `nt_router`

## Requirements
- R1: After reset, `xbank` is 0, `xbank_valid` is 0, `vid_rvalid` is 0, and all configuration registers are 0.
- R2: Register 0 (mapping) holds the source of quadrant q in bits 2q+1:2q. Quadrant q is `vid_addr[11:10]` and the offset is `vid_addr[9:0]`. The codes are 0 = page 0, 1 = page 1, 2 = expansion RAM, 3 = fill. A read accepted at one edge is answered with `vid_rvalid` high after the next edge. A write to a page or to expansion RAM stores the byte at that offset.
- R3: In a fill quadrant, offsets below 0x3C0 read register 2 (fill tile). Offsets 0x3C0 and above read register 3 (fill palette, bits 1:0), expanded so the palette appears in all four 2-bit fields (0x00, 0x55, 0xAA, 0xFF).
- R4: In an expansion-RAM quadrant, reads return 0x00 while bit 1 of register 1 (expansion control) is set. Otherwise they return the stored byte. Writes update the RAM in either case.
- R5: Writes to a fill quadrant change no memory.
- R6: When register 1 equals 1, a non-debug read of a page quadrant at an offset below 0x3C0 returns the page byte. It also latches `xbank` = {register 4 bits 1:0, expansion byte bits 5:0} and the palette = expansion byte bits 7:6 from the same offset, and it sets `xbank_valid`.
- R7: When register 1 equals 1, a read of a page quadrant at an offset of 0x3C0 or above returns the latched palette, expanded. This holds also for the read accepted directly after the capturing tile read.
- R8: Debug reads (`vid_dbg` high) never change the latched bank, palette or valid flag.
- R9: A write to register 4 (upper bank), register 5 (graphics mode) or registers 8 to 15 (graphics banks) clears `xbank_valid`. When such a write coincides with a capture, the cleared flag wins.
- R10: No capture or substitution happens for expansion-RAM or fill quadrants, or when register 1 is not 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| vid_valid | input | 1 | Video request valid |
| vid_ready | output | 1 | Video request ready (always high) |
| vid_we | input | 1 | Request is a write |
| vid_dbg | input | 1 | Read without side effects |
| vid_addr | input | 12 | Quadrant and offset |
| vid_wdata | input | 8 | Write data |
| vid_rvalid | output | 1 | Read response valid |
| vid_rdata | output | 8 | Read response data |
| xbank | output | 8 | Latched per-tile graphics bank |
| xbank_valid | output | 1 | Latched bank is current |

## Verification
The hardest situation to reach is a tile read and an attribute read issued back to back. Here the substituted palette must come from the capture that completes on the same edge that accepts the attribute read. The bench issues requests on consecutive cycles as a stream, both in random runs and in a directed pair. The coincidence of a bank-register write with a capture is forced by a directed sequence that places the configuration write in the cycle right after a tile read. Random runs bias the expansion control toward the capturing value and mix in debug reads.

// File: rtl/nt_pkg.sv
package nt_pkg;
  typedef enum logic [1:0] {
    SRC_PAGE0 = 2'd0,
    SRC_PAGE1 = 2'd1,
    SRC_XRAM  = 2'd2,
    SRC_FILL  = 2'd3
  } nt_src_e;

  localparam logic [3:0] CFG_MAP   = 4'h0;
  localparam logic [3:0] CFG_XCTL  = 4'h1;
  localparam logic [3:0] CFG_FTILE = 4'h2;
  localparam logic [3:0] CFG_FPAL  = 4'h3;
  localparam logic [3:0] CFG_UPPER = 4'h4;
  localparam logic [3:0] CFG_GMODE = 4'h5;

  // spread a 2-bit palette over every field of an attribute byte
  function automatic logic [7:0] nt_expand(input logic [1:0] pal);
    return {4{pal}};
  endfunction
endpackage

// File: rtl/nt_byte_ram.sv
module nt_byte_ram #(
  parameter int DEPTH = 1024,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/nt_cfg_regs.sv
module nt_cfg_regs
  import nt_pkg::*;
#(
  parameter int QUADS = 4,
  parameter int UP_W  = 2,
  localparam int MAP_W = 2 * QUADS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [3:0]       addr,
  input  logic [7:0]       wdata,
  output logic [MAP_W-1:0] map_q,
  output logic [1:0]       xctl_q,
  output logic [7:0]       ftile_q,
  output logic [7:0]       fattr_q,
  output logic [UP_W-1:0]  upper_q,
  output logic             bank_clr
);
  // graphics-side registers live elsewhere; only their write events matter here
  assign bank_clr = we && (addr[3] || addr == CFG_UPPER || addr == CFG_GMODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q   <= '0;
      xctl_q  <= '0;
      ftile_q <= '0;
      fattr_q <= '0;
      upper_q <= '0;
    end else if (we) begin
      case (addr)
        CFG_MAP:   map_q   <= wdata[MAP_W-1:0];
        CFG_XCTL:  xctl_q  <= wdata[1:0];
        CFG_FTILE: ftile_q <= wdata;
        CFG_FPAL:  fattr_q <= nt_expand(wdata[1:0]);
        CFG_UPPER: upper_q <= wdata[UP_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nt_xattr_latch.sv
module nt_xattr_latch #(
  parameter int DW    = 8,
  parameter int LOW_W = 6,
  parameter int UP_W  = 2,
  parameter int PAL_W = 2,
  localparam int BANK_W = LOW_W + UP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [DW-1:0]     cap_byte,
  input  logic [UP_W-1:0]   upper,
  input  logic              clr,
  output logic [BANK_W-1:0] bank_q,
  output logic [PAL_W-1:0]  pal_q,
  output logic              valid_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q  <= '0;
      pal_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (cap) begin
        bank_q <= {upper, cap_byte[LOW_W-1:0]};
        pal_q  <= cap_byte[DW-1 -: PAL_W];
      end
      // a register write that invalidates the bank outranks a capture
      if (clr)      valid_q <= 1'b0;
      else if (cap) valid_q <= 1'b1;
    end
  end
endmodule

// File: rtl/nt_router.sv
module nt_router
  import nt_pkg::*;
#(
  parameter int OFS_W     = 10,
  parameter int QUAD_W    = 2,
  parameter int UP_W      = 2,
  parameter int LOW_W     = 6,
  parameter int ATTR_BASE = 'h3C0,
  localparam int ADDR_W = OFS_W + QUAD_W,
  localparam int QUADS  = 1 << QUAD_W,
  localparam int BANK_W = UP_W + LOW_W,
  localparam int PAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              vid_valid,
  output logic              vid_ready,
  input  logic              vid_we,
  input  logic              vid_dbg,
  input  logic [ADDR_W-1:0] vid_addr,
  input  logic [7:0]        vid_wdata,
  output logic              vid_rvalid,
  output logic [7:0]        vid_rdata,
  output logic [BANK_W-1:0] xbank,
  output logic              xbank_valid
);
  logic [2*QUADS-1:0] map_q;
  logic [1:0]         xctl_q;
  logic [7:0]         ftile_q, fattr_q;
  logic [UP_W-1:0]    upper_q;
  logic               bank_clr;

  nt_cfg_regs #(.QUADS(QUADS), .UP_W(UP_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .map_q(map_q), .xctl_q(xctl_q), .ftile_q(ftile_q), .fattr_q(fattr_q),
    .upper_q(upper_q), .bank_clr(bank_clr)
  );

  // request decode
  logic [QUAD_W-1:0] quad;
  logic [OFS_W-1:0]  ofs;
  nt_src_e           src;
  logic              is_attr, is_page, xmode, acc;

  assign vid_ready = 1'b1;
  assign acc       = vid_valid;
  assign quad      = vid_addr[ADDR_W-1:OFS_W];
  assign ofs       = vid_addr[OFS_W-1:0];
  assign src       = nt_src_e'(map_q[{quad, 1'b0} +: 2]);
  assign is_attr   = ofs >= OFS_W'(ATTR_BASE);
  assign is_page   = (src == SRC_PAGE0) || (src == SRC_PAGE1);
  assign xmode     = (xctl_q == 2'd1);

  // storage
  logic [7:0] page_q, xram_q;

  nt_byte_ram #(.DEPTH(PAGES << OFS_W), .DW(8)) page_ram_i (
    .clk(clk), .we(acc && vid_we && is_page), .addr({src[0], ofs}),
    .wdata(vid_wdata), .rdata(page_q)
  );

  nt_byte_ram #(.DEPTH(1 << OFS_W), .DW(8)) xram_i (
    .clk(clk), .we(acc && vid_we && src == SRC_XRAM), .addr(ofs),
    .wdata(vid_wdata), .rdata(xram_q)
  );

  // response stage
  logic    s_rd, s_attr, s_x, s_blk, s_cap;
  nt_src_e s_src;
  logic [7:0] s_fill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_rd   <= 1'b0;
      s_attr <= 1'b0;
      s_x    <= 1'b0;
      s_blk  <= 1'b0;
      s_cap  <= 1'b0;
      s_src  <= SRC_PAGE0;
      s_fill <= '0;
    end else begin
      s_rd   <= acc && !vid_we;
      s_attr <= is_attr;
      s_x    <= xmode;
      s_blk  <= xctl_q[1];
      s_cap  <= acc && !vid_we && !vid_dbg && xmode && is_page && !is_attr;
      s_src  <= src;
      s_fill <= is_attr ? fattr_q : ftile_q;
    end
  end

  logic [1:0] pal_q;

  nt_xattr_latch #(.DW(8), .LOW_W(LOW_W), .UP_W(UP_W), .PAL_W(2)) xattr_i (
    .clk(clk), .rst_n(rst_n), .cap(s_cap), .cap_byte(xram_q), .upper(upper_q),
    .clr(bank_clr), .bank_q(xbank), .pal_q(pal_q), .valid_q(xbank_valid)
  );

  assign vid_rvalid = s_rd;

  always_comb begin
    unique case (s_src)
      SRC_PAGE0, SRC_PAGE1: vid_rdata = (s_x && s_attr) ? nt_expand(pal_q) : page_q;
      SRC_XRAM:             vid_rdata = s_blk ? 8'h00 : xram_q;
      default:              vid_rdata = s_fill;
    endcase
  end
endmodule

// File: rtl/nt_router_chk.sv
module nt_router_chk #(
  parameter int BANK_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [3:0]        cfg_addr,
  input logic              vid_valid,
  input logic              vid_we,
  input logic              vid_dbg,
  input logic              vid_rvalid,
  input logic [BANK_W-1:0] xbank,
  input logic              xbank_valid
);
  assert_rsp_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vid_rvalid |-> $past(vid_valid && !vid_we));

  assert_clear_on_gfx_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_addr[3] || cfg_addr == 4'h4 || cfg_addr == 4'h5)) |=> !xbank_valid);

  assert_bank_moves_after_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(xbank) |-> $past(vid_valid && !vid_we && !vid_dbg, 2));

  assert_no_debug_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xbank_valid) |-> $past(vid_valid && !vid_we && !vid_dbg, 2));

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!xbank_valid && !vid_rvalid && xbank == '0));
endmodule

bind nt_router nt_router_chk #(.BANK_W(BANK_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .vid_valid(vid_valid), .vid_we(vid_we), .vid_dbg(vid_dbg),
  .vid_rvalid(vid_rvalid), .xbank(xbank), .xbank_valid(xbank_valid)
);

// File: tb/nt_router_tb.sv
module nt_router_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic vid_valid = 1'b0, vid_we = 1'b0, vid_dbg = 1'b0;
  logic [11:0] vid_addr = '0;
  logic [7:0] vid_wdata = '0;
  logic vid_ready, vid_rvalid, xbank_valid;
  logic [7:0] vid_rdata, xbank;

  always #10 clk = ~clk;

  nt_router dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .vid_valid(vid_valid), .vid_ready(vid_ready), .vid_we(vid_we), .vid_dbg(vid_dbg),
    .vid_addr(vid_addr), .vid_wdata(vid_wdata), .vid_rvalid(vid_rvalid),
    .vid_rdata(vid_rdata), .xbank(xbank), .xbank_valid(xbank_valid)
  );

  int n_chk = 0, n_bad = 0;

  // reference model state
  logic [7:0] m_page [2048];
  logic [7:0] m_xram [1024];
  logic [7:0] m_map = 0, m_ftile = 0, m_fpal = 0;
  logic [1:0] m_xctl = 0, m_upper = 0, m_pal = 0;
  logic [7:0] m_bank = 0;
  logic       m_bv = 0;

  logic       pend_v = 0;
  logic [7:0] pend_d = 0;
  string      pend_tag = "";

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expand(input logic [1:0] p);
    return {p, p, p, p};
  endfunction

  task automatic check_pending();
    if (pend_v) chk(pend_tag, {7'd0, vid_rvalid, vid_rdata}, {8'h01, pend_d});
  endtask

  // one video request per call, issued at the falling edge
  task automatic issue(input logic we, input logic dbg, input logic [11:0] a, input logic [7:0] d);
    logic [1:0] q, s;
    logic [9:0] o;
    logic attr;
    @(negedge clk);
    check_pending();
    cfg_we = 0; vid_valid = 1; vid_we = we; vid_dbg = dbg; vid_addr = a; vid_wdata = d;
    q = a[11:10]; o = a[9:0]; s = m_map[2*q +: 2]; attr = (o >= 10'h3C0);
    pend_v = !we;
    pend_tag = "R2";
    if (we) begin
      if (s <= 2'd1) m_page[{s[0], o}] = d;
      else if (s == 2'd2) m_xram[o] = d;
    end else begin
      case (s)
        2'd0, 2'd1: begin
          if (m_xctl == 2'd1 && attr) begin
            pend_d = expand(m_pal); pend_tag = "R7";
          end else begin
            pend_d = m_page[{s[0], o}];
            if (m_xctl == 2'd1) pend_tag = "R6";
          end
          if (m_xctl == 2'd1 && !attr && !dbg) begin
            m_pal = m_xram[o][7:6];
            m_bank = {m_upper, m_xram[o][5:0]};
            m_bv = 1;
          end
        end
        2'd2: begin pend_d = m_xctl[1] ? 8'h00 : m_xram[o]; pend_tag = "R4"; end
        default: begin pend_d = attr ? expand(m_fpal[1:0]) : m_ftile; pend_tag = "R3"; end
      endcase
    end
  endtask

  task automatic cfg_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    check_pending();
    pend_v = 0;
    vid_valid = 0; cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    case (a)
      4'h0: m_map = d;
      4'h1: m_xctl = d[1:0];
      4'h2: m_ftile = d;
      4'h3: m_fpal = {6'd0, d[1:0]};
      4'h4: begin m_upper = d[1:0]; m_bv = 0; end
      4'h5: m_bv = 0;
      default: if (a[3]) m_bv = 0;
    endcase
  endtask

  task automatic idle_check(input string req);
    @(negedge clk);
    check_pending();
    pend_v = 0; vid_valid = 0; cfg_we = 0;
    @(negedge clk);
    chk(req, {7'd0, xbank_valid, xbank}, {7'd0, m_bv, m_bank});
  endtask

  function automatic logic [11:0] rnd_addr();
    logic [9:0] o;
    o = ($urandom % 2) ? 10'(10'h3C0 + $urandom % 64) : 10'($urandom % 960);
    return {2'($urandom), o};
  endfunction

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {7'd0, xbank_valid, xbank}, 16'h0);
    chk("R1", {15'd0, vid_rvalid}, 16'h0);
    chk("R1", {15'd0, vid_ready}, 16'h1);

    // fill all memories: q0 page0, q1 page1, q2 xram, q3 fill
    cfg_wr(4'h0, 8'hE4);
    for (int i = 0; i < 3072; i++) issue(1, 0, 12'(i), 8'($urandom));
    for (int i = 0; i < 20; i++) issue(0, 0, rnd_addr(), 0);

    // R3 fill tile/attribute and the 0x3C0 boundary
    cfg_wr(4'h2, 8'h5A);
    cfg_wr(4'h3, 8'hFE);
    issue(0, 0, 12'hC10, 0);
    issue(0, 0, 12'hFBF, 0);
    issue(0, 0, 12'hFC0, 0);

    // R5 write into a fill quadrant touches no memory
    issue(1, 0, 12'hC05, 8'h77);
    issue(0, 0, 12'h005, 0);
    issue(0, 0, 12'h405, 0);
    issue(0, 0, 12'h805, 0);

    // R4 blocked expansion reads, writes still land
    cfg_wr(4'h1, 8'h02);
    issue(1, 0, 12'h833, 8'h3C);
    issue(0, 0, 12'h833, 0);
    cfg_wr(4'h1, 8'h00);
    issue(0, 0, 12'h833, 0);

    // R6 / R7 capture then back-to-back attribute
    cfg_wr(4'h4, 8'h03);
    issue(1, 0, 12'h821, 8'hC5);
    cfg_wr(4'h1, 8'h01);
    issue(0, 0, 12'h021, 0);
    issue(0, 0, 12'h3C8, 0);
    idle_check("R6");

    // R8 debug tile read does not capture
    issue(1, 0, 12'h822, 8'h41);
    issue(0, 1, 12'h422, 0);
    issue(0, 0, 12'h7C1, 0);
    idle_check("R8");

    // R9 gfx bank write clears; coincident with capture, clear wins
    cfg_wr(4'h9, 8'h10);
    idle_check("R9");
    issue(0, 0, 12'h022, 0);
    cfg_wr(4'hB, 8'h00);
    idle_check("R9");

    // R10 no substitution for expansion quadrant or other control values
    issue(0, 0, 12'hBC0, 0);
    cfg_wr(4'h1, 8'h00);
    issue(0, 0, 12'h3C0, 0);
    issue(0, 0, 12'h010, 0);
    idle_check("R10");

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 100;
      if (r < 55)      issue(0, 0, rnd_addr(), 0);
      else if (r < 68) issue(0, 1, rnd_addr(), 0);
      else if (r < 88) issue(1, 0, rnd_addr(), 8'($urandom));
      else if (r < 91) cfg_wr(4'h1, ($urandom % 2) ? 8'h01 : 8'($urandom));
      else if (r < 93) cfg_wr(4'h0, 8'($urandom));
      else if (r < 95) cfg_wr(4'($urandom % 6), 8'($urandom));
      else if (r < 96) cfg_wr(4'h8 | 4'($urandom % 8), 8'($urandom));
      else             idle_check("R6");
    end
    idle_check("R9");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule